// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block supervises a multiphase buck converter for sustained overcurrent. Each phase's current arrives as a digital sample word, and all phases are packed into one stream beat. The block adds the phase values together and compares the sum with a trip level scaled by the phase count. This is the same as comparing the phase average against the trip level, and it needs no divider. When the average reaches or exceeds the level, every PWM output is released to high impedance in the same cycle.

After a trip, the block holds the PWM outputs off for a wait that lasts as long as one soft-start interval. It then requests a new soft-start. A trip during that soft-start sends it back into a full wait. Six such retries are allowed. The seventh overcurrent event in a row latches the converter off until the enable is dropped or reset is applied. A soft-start that completes cleanly returns the converter to regulation and clears the run of events.

Timing is counted in ticks, for example one per switching cycle. The wait length and the soft-start length are the same parameter. The sample stream uses valid/ready with these rules:
- `samp_ready` is high only while the converter is soft-starting or regulating.
- A beat is consumed on any cycle where `samp_valid` and `samp_ready` are both high.
- Samples offered while `samp_ready` is low are dropped, not stalled. Each beat is a snapshot, so a producer never has to hold data.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: A consumed beat trips when the sum of its PHASES unsigned samples is greater than or equal to TRIP_LEVEL*PHASES (default 90*4 = 360). Phase i sits at bits [i*SAMPLE_W +: SAMPLE_W]. A single high phase with a lower average does not trip.
- R2: `samp_ready` is high only while soft-starting or regulating. A beat with `samp_valid` low, or offered while `samp_ready` is low, has no effect on any output or on any timing.
- R3: In the cycle a tripping beat is consumed, `pwm_hiz` is high, with no register in that path.
- R4: After a trip that does not latch, the wait lasts until SS_TICKS ticks have been counted, and `ss_req` rises in the next cycle. Cycles with `tick` low lengthen the wait.
- R5: `ss_req` is high for the soft-start, which ends after SS_TICKS ticks. A trip during a soft-start drives `pwm_hiz` high at once and begins a new full wait.
- R6: After six retries, the seventh consecutive trip sets `latched_off` in the next cycle, and no further soft-start is requested.
- R7: While `latched_off` is high, `pwm_hiz` is high, `pgood` is low, `ss_req` is low, and the state holds regardless of samples. Dropping `en` clears it, and raising `en` again starts a fresh soft-start.
- R8: A soft-start that completes without a trip clears the consecutive-event run. Any number of separated trips with clean recoveries never latches.
- R9: `pgood` rises in the cycle regulation begins. It falls the cycle after `uv_flag` is seen high, or when a soft-start begins, and it stays low through retries that trip again.
- R10: In reset, and while `en` is low, these outputs hold the following values. `en` going high starts a soft-start on the next clock.

  | Output | Value |
  |---|---|
  | `pwm_hiz` | 1 |
  | `ss_req` | 0 |
  | `pgood` | 0 |
  | `latched_off` | 0 |
  | `samp_ready` | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable; low forces off and clears latch-off |
| samp_valid | input | 1 | Current sample beat valid |
| samp_ready | output | 1 | Block is consuming current samples |
| samp_data | input | PHASES*SAMPLE_W | Packed per-phase current samples |
| uv_flag | input | 1 | Output below undervoltage threshold |
| tick | input | 1 | Timing tick for wait and soft-start counting |
| pwm_hiz | output | 1 | Release all PWM outputs to high impedance |
| ss_req | output | 1 | Soft-start in progress request |
| pgood | output | 1 | Power good |
| latched_off | output | 1 | Converter latched off after repeated trips |

## Verification
The hardest state to reach is the seventh consecutive trip. It needs six retry soft-starts, and each must trip again before it completes, with no clean soft-start anywhere in the run. The bench reaches it by holding a short-circuit-level sample stream valid from regulation onward. Every soft-start then trips in its first cycle, and the bench counts `ss_req` rises until latch-off. The opposite sequence is run as well: trips separated by clean recoveries, to show the run clears. Wait lengths are measured with gaps in `tick`.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_LATCH = 3'd4
  } ocp_state_e;

endpackage

// File: rtl/ocp_avg_trip.sv
module ocp_avg_trip #(
  parameter int PHASES     = 4,
  parameter int SAMPLE_W   = 8,
  parameter int TRIP_LEVEL = 90
) (
  input  logic                       take,
  input  logic [PHASES*SAMPLE_W-1:0] data,
  output logic                       trip
);
  localparam int SUM_W = SAMPLE_W + $clog2(PHASES) + 1;
  localparam logic [SUM_W-1:0] THRESH = SUM_W'(TRIP_LEVEL * PHASES);

  logic [SAMPLE_W-1:0] phase_v [PHASES];
  logic [SUM_W-1:0]    total;

  for (genvar g = 0; g < PHASES; g++) begin : g_unpack
    assign phase_v[g] = data[g*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < PHASES; i++) begin
      total = total + SUM_W'(phase_v[i]);
    end
  end

  assign trip = take && (total >= THRESH);

endmodule

// File: rtl/ocp_tick_timer.sv
module ocp_tick_timer #(
  parameter int LEN = 2040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && tick && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && tick && (cnt == LAST);

endmodule

// File: rtl/ocp_retry_count.sv
module ocp_retry_count #(
  parameter int MAX_RETRIES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic final_evt
);
  localparam int NW = $clog2(MAX_RETRIES + 1);
  localparam logic [NW-1:0] TOP = NW'(MAX_RETRIES);

  logic [NW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clr) begin
      run_cnt <= '0;
    end else if (inc && (run_cnt != TOP)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign final_evt = (run_cnt == TOP);

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
  import ocp_pkg::*;
#(
  parameter int PHASES      = 4,
  parameter int SAMPLE_W    = 8,
  parameter int TRIP_LEVEL  = 90,
  parameter int SS_TICKS    = 2040,
  parameter int MAX_RETRIES = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       samp_valid,
  output logic                       samp_ready,
  input  logic [PHASES*SAMPLE_W-1:0] samp_data,
  input  logic                       uv_flag,
  input  logic                       tick,
  output logic                       pwm_hiz,
  output logic                       ss_req,
  output logic                       pgood,
  output logic                       latched_off
);
  ocp_state_e st_q, st_n;
  logic       trip, tmr_done, final_evt;
  logic       tmr_run, tmr_clr, cnt_clr, pg_q;

  assign samp_ready = (st_q == ST_SOFT) || (st_q == ST_RUN);

  ocp_avg_trip #(
    .PHASES(PHASES), .SAMPLE_W(SAMPLE_W), .TRIP_LEVEL(TRIP_LEVEL)
  ) u_avg (
    .take (samp_valid && samp_ready),
    .data (samp_data),
    .trip (trip)
  );

  assign tmr_run = (st_q == ST_SOFT) || (st_q == ST_WAIT);
  assign tmr_clr = (st_n != st_q);

  ocp_tick_timer #(.LEN(SS_TICKS)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .run  (tmr_run),
    .tick (tick),
    .done (tmr_done)
  );

  assign cnt_clr = (st_n == ST_OFF) || ((st_q == ST_SOFT) && (st_n == ST_RUN));

  ocp_retry_count #(.MAX_RETRIES(MAX_RETRIES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (trip),
    .final_evt(final_evt)
  );

  always_comb begin
    st_n = st_q;
    if (!en) begin
      st_n = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:   st_n = ST_SOFT;
        ST_SOFT: begin
          if (trip)          st_n = final_evt ? ST_LATCH : ST_WAIT;
          else if (tmr_done) st_n = ST_RUN;
        end
        ST_RUN:   if (trip) st_n = final_evt ? ST_LATCH : ST_WAIT;
        ST_WAIT:  if (tmr_done) st_n = ST_SOFT;
        ST_LATCH: st_n = ST_LATCH;
        default:  st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      pg_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if ((st_n == ST_OFF) || (st_n == ST_LATCH) || (st_n == ST_SOFT)) begin
        pg_q <= 1'b0;
      end else if ((st_q == ST_SOFT) && (st_n == ST_RUN)) begin
        pg_q <= 1'b1;
      end else if (uv_flag) begin
        pg_q <= 1'b0;
      end
    end
  end

  assign pwm_hiz     = !samp_ready || trip;
  assign ss_req      = (st_q == ST_SOFT);
  assign pgood       = pg_q;
  assign latched_off = (st_q == ST_LATCH);

endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic samp_valid,
  input logic samp_ready,
  input logic pwm_hiz,
  input logic ss_req,
  input logic pgood,
  input logic latched_off
);
  // R7: latch-off holds while enabled
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off && en |=> latched_off);

  // R7: outputs while latched off
  p_latch_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> (pwm_hiz && !pgood && !ss_req && !samp_ready));

  // R10: disable forces the converter off
  p_disable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_hiz && !ss_req && !latched_off && !pgood));

  // R3: a consumed tripping beat stops sampling and keeps PWM released
  p_trip_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && samp_ready && pwm_hiz |=> (!samp_ready && pwm_hiz));

  // R9: no power-good during soft-start
  p_pgood_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> !pgood);

  // R2: samples are only taken while not latched
  p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready |-> !latched_off);

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .samp_valid (samp_valid),
  .samp_ready (samp_ready),
  .pwm_hiz    (pwm_hiz),
  .ss_req     (ss_req),
  .pgood      (pgood),
  .latched_off(latched_off)
);

// File: tb/tb_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_ctrl;
  localparam int SS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        samp_valid = 1'b0;
  logic [31:0] samp_data = '0;
  logic        uv_flag = 1'b0;
  logic        tick = 1'b1;
  logic        samp_ready, pwm_hiz, ss_req, pgood, latched_off;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ocp_hiccup_ctrl #(
    .PHASES(4), .SAMPLE_W(8), .TRIP_LEVEL(90), .SS_TICKS(SS), .MAX_RETRIES(6)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .samp_valid(samp_valid),
    .samp_ready(samp_ready), .samp_data(samp_data), .uv_flag(uv_flag),
    .tick(tick), .pwm_hiz(pwm_hiz), .ss_req(ss_req), .pgood(pgood),
    .latched_off(latched_off)
  );

  // {expected trip, phase3, phase2, phase1, phase0}  (R1)
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'd50,  8'd50,  8'd50,  8'd50},
    {1'b1, 8'd90,  8'd90,  8'd90,  8'd90},
    {1'b0, 8'd90,  8'd90,  8'd90,  8'd89},
    {1'b1, 8'd90,  8'd90,  8'd80,  8'd100},
    {1'b0, 8'd34,  8'd35,  8'd35,  8'd255},
    {1'b1, 8'd0,   8'd0,   8'd255, 8'd255},
    {1'b0, 8'd0,   8'd0,   8'd0,   8'd0},
    {1'b1, 8'd0,   8'd120, 8'd120, 8'd120}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // restart from off and return at a negedge with regulation active
  task automatic restart();
    samp_valid = 1'b0;
    tick = 1'b1;
    en = 1'b0;
    cyc();
    en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (pgood) break;
    end
  endtask

  // count wait cycles after a trip; gap cycles with tick low at start
  task automatic measure_wait(input int gap, input bit junk, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      cyc();
      if (ss_req) break;
      if (junk) chk(!samp_ready, "R2 ready low in wait", samp_ready, 0);
      n++;
      tick = (n > gap);
      samp_valid = junk;
      samp_data = 32'hFFFF_FFFF;
    end
    samp_valid = 1'b0;
    tick = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int rises;
    bit prev;

    // R10 reset state
    #1;
    chk(pwm_hiz && !ss_req && !pgood && !latched_off && !samp_ready,
        "R10 reset outputs", {pwm_hiz, ss_req, pgood, latched_off, samp_ready}, 5'b10000);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(pwm_hiz && !ss_req, "R10 disabled idle", ss_req, 0);

    // R5 soft-start length, R10 enable start
    en = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (ss_req) n++;
      else if (n > 0) break;
    end
    chk(n == SS, "R5 soft-start length", n, SS);
    chk(pgood && !pwm_hiz && samp_ready, "R9 pgood in regulation", pgood, 1);

    // R1/R3 table walk: trip visible in same cycle
    for (int v = 0; v < 8; v++) begin
      restart();
      samp_data = VEC[v][31:0];
      samp_valid = 1'b1;
      #1;
      chk(pwm_hiz == VEC[v][32], $sformatf("R1 R3 vector %0d", v), pwm_hiz, VEC[v][32]);
      samp_valid = 1'b0;
    end

    // R2 valid low ignored
    restart();
    samp_data = 32'hFFFF_FFFF;
    samp_valid = 1'b0;
    repeat (3) cyc();
    chk(!pwm_hiz && pgood, "R2 invalid beat ignored", pwm_hiz, 0);

    // R4 plain wait length, R2 junk during wait
    samp_valid = 1'b1;
    #1;
    chk(pwm_hiz, "R3 trip in regulation", pwm_hiz, 1);
    measure_wait(0, 1'b1, n);
    chk(n == SS, "R4 R2 wait length", n, SS);
    chk(!latched_off, "R2 no latch from junk", latched_off, 0);

    // R4 wait stretched by tick gaps
    restart();
    samp_data = 32'hFFFF_FFFF;
    samp_valid = 1'b1;
    cyc();
    samp_valid = 1'b0;
    // one WAIT cycle already passed with tick high; sample from here
    n = 1;
    for (int i = 0; i < 100; i++) begin
      if (ss_req) break;
      tick = (n > 3);
      cyc();
      if (!ss_req) n++;
    end
    tick = 1'b1;
    chk(n == SS + 3, "R4 wait with tick gaps", n, SS + 3);

    // R5 trip during soft-start restarts a full wait
    restart();
    en = 1'b0;
    cyc();
    en = 1'b1;
    cyc();
    cyc();
    chk(ss_req, "R5 in soft-start", ss_req, 1);
    samp_data = 32'hFFFF_FFFF;
    samp_valid = 1'b1;
    #1;
    chk(pwm_hiz, "R5 trip in soft-start hiz", pwm_hiz, 1);
    measure_wait(0, 1'b0, n);
    chk(n == SS, "R5 full wait after soft-start trip", n, SS);

    // R9 pgood after trip and undervoltage
    restart();
    samp_data = 32'hFFFF_FFFF;
    samp_valid = 1'b1;
    cyc();
    samp_valid = 1'b0;
    chk(pgood, "R9 pgood held until undervoltage", pgood, 1);
    uv_flag = 1'b1;
    cyc();
    chk(!pgood, "R9 pgood low after undervoltage", pgood, 0);
    uv_flag = 1'b0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (ss_req) break;
    end
    samp_valid = 1'b1;
    cyc();
    samp_valid = 1'b0;
    chk(!pgood, "R9 pgood low through retry trip", pgood, 0);
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (pgood) break;
    end
    chk(pgood, "R9 pgood back after clean soft-start", pgood, 1);

    // R8 separated trips never latch
    restart();
    for (int k = 0; k < 9; k++) begin
      samp_data = 32'hFFFF_FFFF;
      samp_valid = 1'b1;
      cyc();
      samp_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
        cyc();
        if (pgood) break;
      end
    end
    chk(!latched_off && pgood, "R8 run clears on recovery", latched_off, 0);

    // R6 sustained short: six retries then latch
    restart();
    samp_data = 32'hFFFF_FFFF;
    samp_valid = 1'b1;
    rises = 0;
    prev = 1'b0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (ss_req && !prev) rises++;
      prev = ss_req;
      if (latched_off) break;
    end
    chk(latched_off, "R6 latched after seventh trip", latched_off, 1);
    chk(rises == 6, "R6 retry count", rises, 6);

    // R7 latch holds with normal samples
    samp_data = {4{8'd10}};
    repeat (20) cyc();
    chk(latched_off && pwm_hiz && !pgood && !ss_req && !samp_ready,
        "R7 latched outputs", latched_off, 1);
    samp_valid = 1'b0;
    en = 1'b0;
    cyc();
    chk(!latched_off, "R7 enable drop clears latch", latched_off, 1'b0);
    en = 1'b1;
    cyc();
    chk(ss_req, "R7 fresh soft-start", ss_req, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule